// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup

This block holds a small read cache of sixteen 32-byte lines, organised as eight sets of two ways. A 16-bit request address is cut into tag, set and byte-offset fields. The set field picks one set, both stored tags of that set are compared with the request tag at the same time, and a valid match is a hit. The matching way number is joined to the set number to form the row of a flat sixteen-line data array, and the offset picks one 32-bit word from that row.

A request is registered, and its response (valid, hit, way, word) appears one cycle later. A separate fill port writes a complete line, its tag and its valid bit into any chosen way of any set in a single cycle. The logic around the block decides which way to replace and where the line data comes from.

Top module: `sa_cache_lookup`

## Requirements
- R1: The request address splits as tag = addr[15:8], set = addr[7:5], byte offset = addr[4:0].
- R2: After reset `rsp_valid_o` is 0 and every tag entry is invalid, so any lookup misses until a fill is made.
- R3: `rsp_valid_o` is 1 in the cycle after a cycle with `req_valid_i` = 1, and 0 after a cycle without a request.
- R4: A lookup hits when either way of the selected set holds a valid entry whose tag equals the request tag; `rsp_way_o` gives the way that matched (0 or 1).
- R5: On a hit, `rsp_data_o` is word addr[4:2] of the line at data row {set, way}, where word k sits in line bits [32k+31:32k]; addr[1:0] has no effect.
- R6: On a miss, `rsp_hit_o` is 0 and `rsp_data_o` is 0.
- R7: A fill with `fill_en_i` = 1 writes tag, valid bit and line into row {`fill_set_i`, `fill_way_i`} in one cycle; a request in the next cycle sees it, while a request in the same cycle sees the contents from before the fill.
- R8: A fill changes only its own set and way: the other way of that set and all other sets keep their tags and data, and a line may be placed in either way.
- R9: At most one way of a set matches a request; if both ever did, way 0 would be reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_addr_i | input | 16 | Lookup byte address |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | 1 | Way that matched on a hit |
| rsp_data_o | output | 32 | Addressed word on a hit, zero on a miss |
| fill_en_i | input | 1 | Line fill strobe |
| fill_set_i | input | 3 | Set to fill |
| fill_way_i | input | 1 | Way to fill |
| fill_tag_i | input | 8 | Tag stored with the filled line |
| fill_line_i | input | 256 | Line data, word k in bits [32k+31:32k] |

## Verification
The one-hot match assertion assumes the surrounding logic never stores the same tag in both ways of one set, since the block does not check this itself. The random stimulus keeps to that: before each fill the bench looks at its own model of the other way and moves the new tag off any valid duplicate. Tags are drawn from a small pool so that hits, misses and overwrites all occur often, and fills land in the same cycle as requests to the same set.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned OFF_W  = 5;
  localparam int unsigned SETS   = 8;
  localparam int unsigned WAYS   = 2;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int unsigned LINE_W = 8 << OFF_W;
endpackage

// File: rtl/sa_tag_store.sv
module sa_tag_store #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  match_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_q[rd_set_i][w] && (tag_q[rd_set_i][w] == rd_tag_i);
  end

  // lowest way wins
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end
  assign hit_o = |match_o;

  assert_unique_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o));

  assert_fill_sets_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_set_i)][$past(wr_way_i)]);

  assert_fill_stores_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> tag_q[$past(wr_set_i)][$past(wr_way_i)] == $past(wr_tag_i));
endmodule

// File: rtl/sa_data_store.sv
module sa_data_store #(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned WSEL_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic [ROW_W-1:0]        rd_row_i,
  input  logic [WSEL_W-1:0]       rd_word_i,
  output logic [WORD_W-1:0]       rd_data_o,
  input  logic                    wr_en_i,
  input  logic [ROW_W-1:0]        wr_row_i,
  input  logic [WORDS*WORD_W-1:0] wr_line_i
);
  logic [WORDS-1:0][WORD_W-1:0] line_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[wr_row_i] <= wr_line_i;
  end

  assign rd_data_o = line_q[rd_row_i][rd_word_i];
endmodule

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup
  import sa_cache_pkg::*;
#(
  parameter int unsigned P_SETS   = SETS,
  parameter int unsigned P_WAYS   = WAYS,
  parameter int unsigned P_OFF_W  = OFF_W,
  parameter int unsigned P_WORD_W = WORD_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  localparam int unsigned S_W    = $clog2(P_SETS),
  localparam int unsigned W_W    = $clog2(P_WAYS),
  localparam int unsigned T_W    = P_ADDR_W - S_W - P_OFF_W,
  localparam int unsigned L_W    = 8 << P_OFF_W,
  localparam int unsigned BYTE_W = $clog2(P_WORD_W / 8),
  localparam int unsigned WSEL_W = P_OFF_W - BYTE_W,
  localparam int unsigned NWORDS = 1 << WSEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [P_ADDR_W-1:0] req_addr_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic [W_W-1:0]      rsp_way_o,
  output logic [P_WORD_W-1:0] rsp_data_o,
  input  logic                fill_en_i,
  input  logic [S_W-1:0]      fill_set_i,
  input  logic [W_W-1:0]      fill_way_i,
  input  logic [T_W-1:0]      fill_tag_i,
  input  logic [L_W-1:0]      fill_line_i
);
  logic [T_W-1:0]      req_tag;
  logic [S_W-1:0]      req_set;
  logic [WSEL_W-1:0]   req_word;
  logic                unused_byte;
  logic [P_WAYS-1:0]   match;
  logic                hit;
  logic [W_W-1:0]      way;
  logic [P_WORD_W-1:0] word;

  assign req_tag     = req_addr_i[P_ADDR_W-1 -: T_W];
  assign req_set     = req_addr_i[P_OFF_W +: S_W];
  assign req_word    = req_addr_i[BYTE_W +: WSEL_W];
  assign unused_byte = ^req_addr_i[BYTE_W-1:0];

  sa_tag_store #(.SETS(P_SETS), .WAYS(P_WAYS), .TAG_W(T_W)) i_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_set_i (req_set),
    .rd_tag_i (req_tag),
    .match_o  (match),
    .hit_o    (hit),
    .way_o    (way),
    .wr_en_i  (fill_en_i),
    .wr_set_i (fill_set_i),
    .wr_way_i (fill_way_i),
    .wr_tag_i (fill_tag_i)
  );

  // row = {set, way}: one flat array of sets*ways lines
  sa_data_store #(.ROWS(P_SETS * P_WAYS), .WORDS(NWORDS), .WORD_W(P_WORD_W)) i_data (
    .clk_i     (clk_i),
    .rd_row_i  ({req_set, way}),
    .rd_word_i (req_word),
    .rd_data_o (word),
    .wr_en_i   (fill_en_i),
    .wr_row_i  ({fill_set_i, fill_way_i}),
    .wr_line_i (fill_line_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o  <= hit;
        rsp_way_o  <= hit ? way : '0;
        rsp_data_o <= hit ? word : '0;
      end
    end
  end

  assert_req_gives_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_no_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_miss_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(|match)) |=> (!rsp_hit_o && rsp_data_o == '0));

  assert_hit_way_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && match[0]) |=> (rsp_hit_o && rsp_way_o == '0));
endmodule

// File: tb/test_sa_cache_lookup.sv
module test_sa_cache_lookup;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_addr = '0;
  logic         rsp_valid, rsp_hit, rsp_way;
  logic [31:0]  rsp_data;
  logic         fill_en = 1'b0;
  logic [2:0]   fill_set = '0;
  logic         fill_way = 1'b0;
  logic [7:0]   fill_tag = '0;
  logic [255:0] fill_line = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0]   m_tag   [8][2];
  logic         m_valid [8][2];
  logic [255:0] m_line  [16];

  always #5 clk = ~clk;

  sa_cache_lookup i_sa_cache_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way), .rsp_data_o(rsp_data),
    .fill_en_i(fill_en), .fill_set_i(fill_set), .fill_way_i(fill_way),
    .fill_tag_i(fill_tag), .fill_line_i(fill_line)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd_line();
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[32*k +: 32] = $urandom;
    return l;
  endfunction

  // one cycle: inputs set at negedge, response checked at next negedge
  task automatic cycle(input bit rq, input logic [15:0] a, input bit fe,
                       input logic [2:0] fs, input bit fw, input logic [7:0] ft,
                       input logic [255:0] fl, input string req);
    bit exp_hit, exp_way;
    logic [31:0] exp_data;
    int nmatch;
    logic [2:0] s;
    s = a[7:5];
    exp_hit = 1'b0; exp_way = 1'b0; exp_data = '0; nmatch = 0;
    for (int w = 1; w >= 0; w--) begin
      if (m_valid[s][w] && m_tag[s][w] == a[15:8]) begin
        exp_hit = 1'b1; exp_way = w[0]; nmatch++;
      end
    end
    if (exp_hit) exp_data = m_line[{s, exp_way}][32*a[4:2] +: 32];
    req_valid = rq; req_addr = a;
    fill_en = fe; fill_set = fs; fill_way = fw; fill_tag = ft; fill_line = fl;
    @(posedge clk);
    if (fe) begin
      m_valid[fs][fw] = 1'b1; m_tag[fs][fw] = ft; m_line[{fs, fw}] = fl;
    end
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    chk(rsp_valid == rq, {"R3 ", req}, 32'(rsp_valid), 32'(rq));
    if (rq) begin
      chk(nmatch <= 1, "R9 unique match", nmatch, 1);
      chk(rsp_hit == exp_hit, {"R4 hit ", req}, 32'(rsp_hit), 32'(exp_hit));
      if (exp_hit) begin
        chk(rsp_way == exp_way, {"R4 way ", req}, 32'(rsp_way), 32'(exp_way));
        chk(rsp_data == exp_data, {"R5 data ", req}, rsp_data, exp_data);
      end else begin
        chk(rsp_data == 32'd0, {"R6 miss data ", req}, rsp_data, 32'd0);
      end
    end
  endtask

  task automatic fill(input logic [2:0] s, input bit w, input logic [7:0] t, input string req);
    cycle(1'b0, 16'h0, 1'b1, s, w, t, rnd_line(), req);
  endtask

  task automatic look(input logic [15:0] a, input string req);
    cycle(1'b1, a, 1'b0, 3'd0, 1'b0, 8'h0, '0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++) begin m_valid[s][w] = 1'b0; m_tag[s][w] = '0; end
    for (int r = 0; r < 16; r++) m_line[r] = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 reset rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: every set misses after reset
    for (int s = 0; s < 8; s++) look({8'h00, 3'(s), 5'h0}, "R2 cold miss");
    chk(rsp_hit == 1'b0, "R2 after reset", 32'(rsp_hit), 0);
    // R1 R5: fill set 3 way 1, read all words with varied byte bits
    fill(3'd3, 1'b1, 8'hA5, "R7 fill");
    for (int k = 0; k < 8; k++) look({8'hA5, 3'd3, 3'(k), 2'(k)}, "R5 word select");
    look({8'hA5, 3'd2, 5'h0}, "R1 set field");
    look({8'hA4, 3'd3, 5'h0}, "R6 tag mismatch");
    // R8: way 0 of same set, both present
    fill(3'd3, 1'b0, 8'h3C, "R8 fill way0");
    look({8'h3C, 3'd3, 5'h1C}, "R8 way0");
    look({8'hA5, 3'd3, 5'h04}, "R8 way1 kept");
    // R7: same-cycle fill and request see old contents, next cycle sees new
    cycle(1'b1, {8'h77, 3'd3, 5'h08}, 1'b1, 3'd3, 1'b0, 8'h77, rnd_line(), "R7 same cycle");
    look({8'h77, 3'd3, 5'h08}, "R7 next cycle");
    look({8'h3C, 3'd3, 5'h08}, "R7 overwritten tag");
    look({8'hA5, 3'd3, 5'h10}, "R8 other way");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      logic [7:0] t;
      bit w;
      s = 3'($urandom_range(0, 7));
      t = 8'($urandom_range(0, 3)) << 6;
      w = 1'($urandom);
      if (m_valid[s][!w] && m_tag[s][!w] == t) t = t + 8'd1;
      case ($urandom_range(0, 3))
        0: fill(s, w, t, "R8 random fill");
        1: cycle(1'b1, {8'($urandom_range(0, 3)) << 6, 3'($urandom_range(0, 7)), 5'($urandom)},
                 1'b1, s, w, t, rnd_line(), "R7 random fill+req");
        2: cycle(1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 8'h0, '0, "R3 idle");
        default: look({8'($urandom_range(0, 3)) << 6, 3'($urandom_range(0, 7)), 5'($urandom)},
                      "R4 random lookup");
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule